// File: doc/BRIEF.md
# Sticky Lock and Fault Router

This block keeps a small set of protection bits that software can set but never clear, and uses four of them to connect fault sources to a shared timer break request. The four fault lock bits cover an ECC double error, a supply-voltage monitor event, an SRAM parity error and a CPU lockup. Once a lock bit is set, its source reaches the break output with no register in the path. Two more lock groups drive write-inhibit outputs toward the CPU configuration logic. One group covers the vector table and the memory protection unit. The other covers the secure vector table and interrupt-control lock, the secure memory protection unit and the security attribution unit.

The block also holds two memory-erase status flags. Hardware sets them and software clears them by writing one. They sit in two reset domains: the flag for a full erase survives a system reset and is cleared only by power-on reset. The voltage-monitor configuration (an enable and a 3-bit level) is stored here too. It is frozen while the monitor's lock bit is set.

Access is through a plain single-cycle register write strobe with an address. Reads are combinational from the address.

Top module: `lock_fault_router`

## Requirements
- R1: The fault lock register (address 0; bit 3 ECC double error, bit 2 voltage monitor, bit 1 SRAM parity, bit 0 CPU lockup) sets a bit when a write carries 1 in that position. Writing 0 leaves the bit as it was.
- R2: A system reset (`sys_rst_n` low) or a power-on reset (`por_n` low) returns every lock bit, the monitor configuration and the tamper erase flag to 0.
- R3: `brk_req` is high in the same cycle that any fault source `fault_src[i]` is high while fault lock bit i is set, using the bit mapping of R1. An unlocked source never raises it.
- R4: The monitor configuration register (address 4; bit 0 enable, bits 3:1 level) takes written values while fault lock bit 2 is clear. While that bit is set, writes to it are ignored and `mon_en`/`mon_level` hold.
- R5: Erase flag bit 0 (address 3) is set by a pulse on `erase_full_done` and cleared by writing 1 to bit 0. A system reset leaves it unchanged, and a power-on reset clears it.
- R6: Erase flag bit 16 (address 3) is set by a pulse on `erase_tamper_done` and cleared by writing 1 to bit 16. A system reset clears it.
- R7: When a hardware set and a write-1-to-clear reach the same erase flag in the same cycle, the flag ends set.
- R8: The core lock register (address 1; bit 0 vector-table lock, bit 1 MPU lock) and the secure lock register (address 2; bit 0 vector/interrupt-control lock, bit 1 secure MPU lock, bit 2 attribution-unit lock) are set-only like R1. Their bits appear unchanged on `core_wr_inhibit` and `sec_wr_inhibit`.
- R9: Reads of addresses 5 to 7, and of any bit position not listed above, return 0.
- R10: A write to one address changes no register at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| fault_src | input | 4 | Fault sources: ECC, monitor, parity, lockup (bits 3..0) |
| erase_full_done | input | 1 | Full memory erase complete pulse |
| erase_tamper_done | input | 1 | Cache and crypto-RAM erase complete pulse |
| brk_req | output | 1 | Timer break request |
| mon_en | output | 1 | Voltage monitor enable |
| mon_level | output | 3 | Voltage monitor level |
| core_wr_inhibit | output | 2 | Core lock bits used as write inhibits |
| sec_wr_inhibit | output | 3 | Secure lock bits used as write inhibits |

## Verification
The assertions assume that the two resets are released only away from the clock edge and that writes and hardware erase pulses are clean one-cycle strobes. The erase-flag checks also rely on a write-1-to-clear being the only software path to a flag. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It issues system resets only between operations. Random addresses and data include unmapped addresses and writes of zero to lock registers, so the ignored-write paths get exercised without breaking these assumptions.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  // register addresses
  localparam int unsigned REG_FAULT_LOCK = 0;
  localparam int unsigned REG_CORE_LOCK  = 1;
  localparam int unsigned REG_SEC_LOCK   = 2;
  localparam int unsigned REG_ERASE      = 3;
  localparam int unsigned REG_MON_CFG    = 4;
  localparam int unsigned REG_COUNT      = 5;

  // field positions that other logic decodes
  localparam int unsigned MON_LOCK_BIT     = 2;
  localparam int unsigned ERASE_FULL_BIT   = 0;
  localparam int unsigned ERASE_TAMPER_BIT = 16;
  localparam int unsigned MON_EN_BIT       = 0;
  localparam int unsigned MON_LVL_LSB      = 1;
endpackage

// File: rtl/lfr_sticky_bank.sv
module lfr_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic [W-1:0] set_val,
  output logic [W-1:0] bits_q
);
  logic [W-1:0] set_req;
  assign set_req = set_stb ? set_val : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          r <= 1'b0;
      else if (set_req[i]) r <= 1'b1;
    end
    assign bits_q[i] = r;
  end

  // R1 / R8: a lock bit never returns to 0 outside reset
  a_r1_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((bits_q & $past(bits_q)) == $past(bits_q)));
  // R1 / R8: a bit only rises after a write carrying 1 in its position
  a_r1_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (((bits_q & ~$past(bits_q)) & ~$past(set_req)) == '0));
endmodule

// File: rtl/lfr_erase_flag.sv
module lfr_erase_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hw_set) flag_q <= 1'b1;
    else if (sw_clr) flag_q <= 1'b0;
  end

  // R7: hardware set beats a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_q);
  // R5 / R6: write-1-to-clear alone empties the flag
  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_set) |=> !flag_q);
  // R5 / R6: the flag rises only after a hardware set
  a_r6_rise_from_hw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hw_set));
endmodule

// File: rtl/lfr_mon_cfg.sv
module lfr_mon_cfg #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             frozen,
  input  logic             en_d,
  input  logic [LVL_W-1:0] lvl_d,
  output logic             en_q,
  output logic [LVL_W-1:0] lvl_q
);
  logic wr_accept;
  assign wr_accept = wr_stb && !frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lvl_q <= '0;
    end else if (wr_accept) begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end

  // R4: a frozen configuration holds its value
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frozen) |-> $stable({en_q, lvl_q}));
  // R4: an unfrozen write lands in the next cycle
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !frozen) |=> (en_q == $past(en_d) && lvl_q == $past(lvl_d)));
endmodule

// File: rtl/lfr_break_route.sv
module lfr_break_route #(
  parameter int N = 4
) (
  input  logic [N-1:0] src,
  input  logic [N-1:0] lock,
  output logic         brk
);
  function automatic logic gated_any(input logic [N-1:0] s, input logic [N-1:0] l);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N; i++) acc = acc | (s[i] & l[i]);
    return acc;
  endfunction

  assign brk = gated_any(src, lock);
endmodule

// File: rtl/lock_fault_router.sv
module lock_fault_router
  import lfr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int FAULT_N = 4,
  parameter int CORE_N  = 2,
  parameter int SEC_N   = 3,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [FAULT_N-1:0] fault_src,
  input  logic               erase_full_done,
  input  logic               erase_tamper_done,
  output logic               brk_req,
  output logic               mon_en,
  output logic [LVL_W-1:0]   mon_level,
  output logic [CORE_N-1:0]  core_wr_inhibit,
  output logic [SEC_N-1:0]   sec_wr_inhibit
);
  localparam int NREG = REG_COUNT;

  // combined system domain: power-on reset also resets it
  logic sys_n;
  assign sys_n = por_n & sys_rst_n;

  // write decode, one strobe per register
  logic [NREG-1:0] wr_sel;
  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign wr_sel[k] = wr_en && (addr == ADDR_W'(k));
  end

  logic [FAULT_N-1:0] fault_lock;
  logic [CORE_N-1:0]  core_lock;
  logic [SEC_N-1:0]   sec_lock;

  lfr_sticky_bank #(.W(FAULT_N)) u_fault_lock (
    .clk(clk), .rst_n(sys_n), .set_stb(wr_sel[REG_FAULT_LOCK]),
    .set_val(wdata[FAULT_N-1:0]), .bits_q(fault_lock));

  lfr_sticky_bank #(.W(CORE_N)) u_core_lock (
    .clk(clk), .rst_n(sys_n), .set_stb(wr_sel[REG_CORE_LOCK]),
    .set_val(wdata[CORE_N-1:0]), .bits_q(core_lock));

  lfr_sticky_bank #(.W(SEC_N)) u_sec_lock (
    .clk(clk), .rst_n(sys_n), .set_stb(wr_sel[REG_SEC_LOCK]),
    .set_val(wdata[SEC_N-1:0]), .bits_q(sec_lock));

  assign core_wr_inhibit = core_lock;
  assign sec_wr_inhibit  = sec_lock;

  // erase flags in two reset domains
  logic clr_full, clr_tamper, erase_full, erase_tamper;
  assign clr_full   = wr_sel[REG_ERASE] && wdata[ERASE_FULL_BIT];
  assign clr_tamper = wr_sel[REG_ERASE] && wdata[ERASE_TAMPER_BIT];

  lfr_erase_flag u_erase_full (
    .clk(clk), .rst_n(por_n), .hw_set(erase_full_done),
    .sw_clr(clr_full), .flag_q(erase_full));

  lfr_erase_flag u_erase_tamper (
    .clk(clk), .rst_n(sys_n), .hw_set(erase_tamper_done),
    .sw_clr(clr_tamper), .flag_q(erase_tamper));

  // monitor configuration, frozen by its lock bit
  logic mon_frozen;
  assign mon_frozen = fault_lock[MON_LOCK_BIT];

  lfr_mon_cfg #(.LVL_W(LVL_W)) u_mon_cfg (
    .clk(clk), .rst_n(sys_n), .wr_stb(wr_sel[REG_MON_CFG]), .frozen(mon_frozen),
    .en_d(wdata[MON_EN_BIT]), .lvl_d(wdata[MON_LVL_LSB +: LVL_W]),
    .en_q(mon_en), .lvl_q(mon_level));

  // break routing, no register in the path
  lfr_break_route #(.N(FAULT_N)) u_break (
    .src(fault_src), .lock(fault_lock), .brk(brk_req));

  // read multiplexer
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(REG_FAULT_LOCK): rdata[FAULT_N-1:0] = fault_lock;
      ADDR_W'(REG_CORE_LOCK):  rdata[CORE_N-1:0]  = core_lock;
      ADDR_W'(REG_SEC_LOCK):   rdata[SEC_N-1:0]   = sec_lock;
      ADDR_W'(REG_ERASE): begin
        rdata[ERASE_FULL_BIT]   = erase_full;
        rdata[ERASE_TAMPER_BIT] = erase_tamper;
      end
      ADDR_W'(REG_MON_CFG): begin
        rdata[MON_EN_BIT]              = mon_en;
        rdata[MON_LVL_LSB +: LVL_W]    = mon_level;
      end
      default: rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  // R3: with nothing locked the break request stays low
  a_r3_unlocked_silent: assert property (@(posedge clk) disable iff (!sys_n)
    (fault_lock == '0) |-> !brk_req);
  // R3: a locked, active source raises the break request at once
  a_r3_locked_fires: assert property (@(posedge clk) disable iff (!sys_n)
    ((fault_lock & fault_src) != '0) |-> brk_req);
  // R5: a system reset alone does not disturb the full-erase flag
  a_r5_survives_sys_reset: assert property (@(posedge clk) disable iff (!por_n)
    (!$past(sys_rst_n) && !$past(erase_full_done) && !$past(clr_full)) |-> $stable(erase_full));
endmodule

// File: tb/test_lock_fault_router.sv
`timescale 1ns/1ps
module test_lock_fault_router;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0] fault_src = '0;
  logic erase_full_done = 1'b0, erase_tamper_done = 1'b0;
  logic brk_req, mon_en;
  logic [2:0] mon_level;
  logic [1:0] core_wr_inhibit;
  logic [2:0] sec_wr_inhibit;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state kept from the requirements
  logic [3:0] m_fault;
  logic [1:0] m_core;
  logic [2:0] m_sec;
  logic m_e_full, m_e_tamper, m_en;
  logic [2:0] m_lvl;

  always #5 clk = ~clk;

  lock_fault_router i_lock_fault_router (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fault_src(fault_src),
    .erase_full_done(erase_full_done), .erase_tamper_done(erase_tamper_done),
    .brk_req(brk_req), .mon_en(mon_en), .mon_level(mon_level),
    .core_wr_inhibit(core_wr_inhibit), .sec_wr_inhibit(sec_wr_inhibit));

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {28'd0, m_fault};
      3'd1: return {30'd0, m_core};
      3'd2: return {29'd0, m_sec};
      3'd3: return {15'd0, m_e_tamper, 15'd0, m_e_full};
      3'd4: return {28'd0, m_lvl, m_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_brk(input logic [3:0] s);
    return |(s & m_fault);
  endfunction

  task automatic model_sys_clear(input bit por);
    m_fault = '0; m_core = '0; m_sec = '0; m_e_tamper = 1'b0; m_en = 1'b0; m_lvl = '0;
    if (por) m_e_full = 1'b0;
  endtask

  task automatic model_step(input logic we, input logic [2:0] a, input logic [31:0] d,
                            input logic fe, input logic te);
    logic clr_f, clr_t;
    clr_f = we && a == 3'd3 && d[0];
    clr_t = we && a == 3'd3 && d[16];
    if (we && a == 3'd4 && !m_fault[2]) begin m_en = d[0]; m_lvl = d[3:1]; end
    if (we && a == 3'd0) m_fault = m_fault | d[3:0];
    if (we && a == 3'd1) m_core = m_core | d[1:0];
    if (we && a == 3'd2) m_sec = m_sec | d[2:0];
    m_e_full   = fe ? 1'b1 : (clr_f ? 1'b0 : m_e_full);
    m_e_tamper = te ? 1'b1 : (clr_t ? 1'b0 : m_e_tamper);
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic fe, input logic te);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; erase_full_done = fe; erase_tamper_done = te;
    @(posedge clk); #1;
    wr_en = 1'b0; erase_full_done = 1'b0; erase_tamper_done = 1'b0;
    model_step(we, a, d, fe, te);
  endtask

  task automatic do_sys_reset();
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    model_sys_clear(0);
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    model_sys_clear(1);
  endtask

  task automatic check_all();
    string tags[8] = '{"R1", "R8", "R8", "R5", "R4", "R9", "R9", "R9"};
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk(tags[a], $sformatf("read addr %0d", a), rdata, exp_read(3'(a)));
    end
    chk("R8", "core_wr_inhibit", {30'd0, core_wr_inhibit}, {30'd0, m_core});
    chk("R8", "sec_wr_inhibit", {29'd0, sec_wr_inhibit}, {29'd0, m_sec});
    chk("R4", "mon outputs", {28'd0, mon_level, mon_en}, {28'd0, m_lvl, m_en});
  endtask

  task automatic brk_probe(input logic [3:0] s);
    fault_src = s; #1;
    chk("R3", $sformatf("brk_req src=%b", s), {31'd0, brk_req}, {31'd0, exp_brk(s)});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7351);
    model_sys_clear(1);
    repeat (3) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    check_all();
    brk_probe(4'hF);

    // R4: configure monitor then lock it
    step(1, 3'd4, 32'h0000_000B, 0, 0);
    chk("R4", "mon cfg written", rdata & 0, 0);
    addr = 3'd4; #1; chk("R4", "mon cfg readback", rdata, 32'h0000_000B);
    step(1, 3'd0, 32'h0000_0004, 0, 0);
    step(1, 3'd4, 32'h0000_0000, 0, 0);
    addr = 3'd4; #1; chk("R4", "mon cfg frozen", rdata, 32'h0000_000B);
    // R1: writing zero has no effect
    step(1, 3'd0, 32'h0000_0000, 0, 0);
    addr = 3'd0; #1; chk("R1", "lock survives zero write", rdata, 32'h0000_0004);
    // R3: only the monitor source routes
    brk_probe(4'b0100);
    brk_probe(4'b1011);
    check_all();

    // R8: core and secure locks
    step(1, 3'd1, 32'hFFFF_FFFE, 0, 0);
    step(1, 3'd2, 32'h0000_0005, 0, 0);
    step(1, 3'd2, 32'h0000_0000, 0, 0);
    chk("R8", "sec inhibit", {29'd0, sec_wr_inhibit}, 32'd5);
    chk("R8", "core inhibit", {30'd0, core_wr_inhibit}, 32'd2);

    // R5, R6: hardware sets
    step(0, 3'd0, 0, 1, 1);
    addr = 3'd3; #1; chk("R5", "both erase flags set", rdata, 32'h0001_0001);
    // R2, R5, R6: system reset keeps full flag only
    do_sys_reset();
    addr = 3'd3; #1; chk("R5", "full flag survives sys reset", rdata, 32'h0000_0001);
    addr = 3'd0; #1; chk("R2", "fault lock cleared", rdata, 32'h0);
    check_all();
    // R7: set and clear same cycle
    step(1, 3'd3, 32'h0001_0001, 1, 1);
    addr = 3'd3; #1; chk("R7", "set beats clear", rdata, 32'h0001_0001);
    // R5: plain write-1 clears bit 0 only
    step(1, 3'd3, 32'h0000_0001, 0, 0);
    addr = 3'd3; #1; chk("R5", "w1c bit0", rdata, 32'h0001_0000);
    step(1, 3'd3, 32'h0001_0000, 0, 0);
    addr = 3'd3; #1; chk("R6", "w1c bit16", rdata, 32'h0);
    // R9, R10: unmapped writes disturb nothing
    step(1, 3'd0, 32'h0000_0009, 1, 0);
    for (int a = 5; a < 8; a++) step(1, 3'(a), 32'hFFFF_FFFF, 0, 0);
    check_all();
    // R5: power-on reset clears the full flag
    do_por();
    addr = 3'd3; #1; chk("R5", "por clears full flag", rdata, 32'h0);
    check_all();

    // random phase, R10 cross-register isolation
    for (int n = 0; n < 600; n++) begin
      logic [31:0] d;
      logic [2:0] a;
      logic we, fe, te;
      a  = 3'($urandom % 8);
      d  = $urandom & ($urandom | 32'h0001_000F);
      we = ($urandom % 4) != 0;
      fe = ($urandom % 8) == 0;
      te = ($urandom % 8) == 0;
      if (($urandom % 48) == 0) do_sys_reset();
      else step(we, a, d, fe, te);
      brk_probe(4'($urandom));
      if (n % 6 == 5) check_all();
    end
    check_all();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule